// File: doc/BRIEF.md
# Accelerator Port Soft-Reset Controller

This block manages the soft reset of one accelerator port. Software talks to it through 64-bit registers: a control word, a status word and a capability word. Setting the reset-request bit in the control word starts a reset sequence. From the moment the request is visible, the port stops granting new accelerator requests and stops forwarding host MMIO accesses. It then waits for two things: the count of in-flight requests must fall to zero, and a parameterised minimum reset width must elapse. Only then does it raise the acknowledge bit. Clearing the request bit starts the exit. After a two-cycle settle, the acknowledge bit and the internal accelerator reset fall together.

The port comes out of power-on reset already held in reset, with the acknowledge bit set. Software clears the request bit to bring the accelerator up. Any host MMIO access that arrives while the port is blocked is dropped, and one cycle later it is flagged on an error output.

The control word also carries a latency-tolerance bit that software can read and write. The status word carries event flags, which hardware sets and software clears by writing one to the flag's bit. It also carries a read-only power-state field taken from an input. The capability word returns a fixed port number.

Top module: `port_softreset_ctl`

## Requirements
- R1: After power-on reset the control word reads 0x011 (request bit 0 = 1, acknowledge bit 4 = 1, latency bit 8 = 0), and `accelRst` is 1.
- R2: With a reset request pending, acknowledge bit 4 rises only once no requests are outstanding and the port has been in reset for MIN_PULSE cycles. With nothing outstanding, acknowledge first reads 1 exactly MIN_PULSE+1 clock edges after the edge that wrote the request bit.
- R3: When request bit 0 is cleared while acknowledge is 1, acknowledge and `accelRst` both fall on the third clock edge after the write edge, and on the same edge.
- R4: `reqGrant` is 0 from the cycle the request bit reads 1 until the port has fully left reset. While the port is running, `reqGrant` follows `reqIssue`.
- R5: A host access (`mmioValid`) made while the port is blocked is not forwarded (`mmioFwd` = 0), and `mmioErr` is 1 in the following cycle. While the port is running, the access is forwarded and `mmioErr` stays 0.
- R6: Latency bit 8 of the control word (address 0) is read/write. A write to the control word updates only bits 0 and 8, and writes to acknowledge bit 4 are ignored.
- R7: Status word (address 1) bits 0 and 1 are event flags. A pulse on `evtSet[i]` sets flag i. Writing 1 to bit i clears it; writing 0 leaves it unchanged.
- R8: Status bits [11:8] always show `pwrState`. The capability word (address 2) bits [7:0] always read PORT_ID, and writes to it are ignored. Address 3 reads 0.
- R9: If request bit 0 is cleared before acknowledge has risen, the controller still completes the drain and the minimum width. It raises acknowledge on the same edge R2 gives, then exits as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address (0 control, 1 status, 2 capability) |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data for regAddr (combinational) |
| reqIssue | input | 1 | Accelerator wants to issue a request |
| reqGrant | output | 1 | Request accepted; counted as outstanding |
| reqDone | input | 1 | One outstanding request completed |
| mmioValid | input | 1 | Host MMIO access to the accelerator |
| mmioFwd | output | 1 | Access forwarded to the accelerator |
| mmioErr | output | 1 | Access was dropped while blocked (one cycle later) |
| evtSet | input | NUM_EVT | Hardware event pulses that set the status flags |
| pwrState | input | PWR_W | Current power state, shown in the status word |
| accelRst | output | 1 | Reset held on the accelerator logic |

## Verification
The bench raises a reset request while requests are still outstanding. A controller that ignored the drain would raise acknowledge early, and the bench would see the bit set before the last completion. With nothing outstanding, it checks the exact edge on which acknowledge rises: an off-by-one in the width counter would show acknowledge one cycle early or late. It also clears the request during the drain. A controller that aborted there would never raise acknowledge, or would release `accelRst` ahead of time. Finally it writes zeros and ones to the event flags and the read-only fields, which catches a flag that a written 0 clears or a field that a write can alter.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_DRAIN, ST_HELD, ST_SETTLE1, ST_SETTLE2
  } prtState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic blockNew;
    logic portInRst;
    logic ackOut;
  } prtStrobe_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_CAP  = 2;
  localparam int unsigned REQ_BIT   = 0;
  localparam int unsigned ACK_BIT   = 4;
  localparam int unsigned LAT_BIT   = 8;
  localparam int unsigned PWR_LSB   = 8;
endpackage

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqBit,
  input  logic       drainDone,
  output prtStrobe_t strobe
);
  localparam int unsigned PC_W = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(MIN_PULSE - 1);

  prtState_t state;
  logic [PC_W-1:0] pulseCnt;
  logic pulseDone;

  assign pulseDone = (pulseCnt == PC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HELD;
      pulseCnt <= PC_LAST;
    end else begin
      case (state)
        ST_RUN: if (reqBit) begin
          state    <= ST_DRAIN;
          pulseCnt <= '0;
        end
        ST_DRAIN: begin
          if (!pulseDone) pulseCnt <= pulseCnt + 1'b1;
          if (pulseDone && drainDone) state <= ST_HELD;
        end
        ST_HELD:    if (!reqBit) state <= ST_SETTLE1;
        ST_SETTLE1: state <= ST_SETTLE2;
        ST_SETTLE2: state <= ST_RUN;
        default:    state <= ST_HELD;
      endcase
    end
  end

  always_comb begin
    strobe.portInRst = (state != ST_RUN);
    strobe.blockNew  = (state != ST_RUN) || reqBit;
    strobe.ackOut    = (state == ST_HELD) || (state == ST_SETTLE1) ||
                       (state == ST_SETTLE2);
  end

  AST_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ackOut) |-> $past(drainDone)); // R2
  AST_ACK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ackOut) |-> $past(pulseCnt) == PC_LAST); // R2
  AST_ACK_FALL_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.ackOut) |-> $past(state) == ST_SETTLE2); // R3
  AST_RST_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.portInRst) |-> $fell(strobe.ackOut)); // R3
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !reqBit) |=> state != ST_RUN); // R9
endmodule

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned NUM_EVT = 2,
  parameter int unsigned PWR_W   = 4,
  parameter logic [7:0]  PORT_ID = 8'h03
) (
  input  logic               clk,
  input  logic               rstN,
  input  prtStrobe_t         strobe,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  input  logic               reqIssue,
  output logic               reqGrant,
  input  logic               reqDone,
  input  logic               mmioValid,
  output logic               mmioFwd,
  output logic               mmioErr,
  input  logic [NUM_EVT-1:0] evtSet,
  input  logic [PWR_W-1:0]   pwrState,
  output logic               reqBit,
  output logic               drainDone
);
  logic latBit;
  logic [NUM_EVT-1:0] evtFlag;
  logic [CNT_W-1:0] outCnt;
  logic wrCtrl, wrStat, doneEff;

  assign wrCtrl    = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrStat    = regWrEn && (regAddr == ADDR_W'(ADDR_STAT));
  assign reqGrant  = reqIssue && !strobe.blockNew;
  assign mmioFwd   = mmioValid && !strobe.blockNew;
  assign drainDone = (outCnt == '0);
  assign doneEff   = reqDone && (outCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit  <= 1'b1;
      latBit  <= 1'b0;
      outCnt  <= '0;
      mmioErr <= 1'b0;
    end else begin
      if (wrCtrl) begin
        reqBit <= regWrData[REQ_BIT];
        latBit <= regWrData[LAT_BIT];
      end
      if (reqGrant && !doneEff)      outCnt <= outCnt + 1'b1;
      else if (!reqGrant && doneEff) outCnt <= outCnt - 1'b1;
      mmioErr <= mmioValid && strobe.blockNew;
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : gEvt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          evtFlag[i] <= 1'b0;
      else if (evtSet[i]) evtFlag[i] <= 1'b1;
      else if (wrStat && regWrData[i]) evtFlag[i] <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CTRL): begin
        regRdData[REQ_BIT] = reqBit;
        regRdData[ACK_BIT] = strobe.ackOut;
        regRdData[LAT_BIT] = latBit;
      end
      ADDR_W'(ADDR_STAT): begin
        regRdData[NUM_EVT-1:0] = evtFlag;
        regRdData[PWR_LSB +: PWR_W] = pwrState;
      end
      ADDR_W'(ADDR_CAP): regRdData[7:0] = PORT_ID;
      default: regRdData = '0;
    endcase
  end

  AST_MMIO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (mmioValid && strobe.portInRst) |=> mmioErr); // R5
  AST_LAT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> latBit == $past(regWrData[LAT_BIT])); // R6
  AST_EVT_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !regWrData[0] && evtFlag[0]) |=> evtFlag[0]); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (drainDone && !reqGrant) |=> drainDone); // R2
  AST_NO_GRANT_IN_RST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.portInRst |-> !reqGrant); // R4
endmodule

// File: rtl/port_softreset_ctl.sv
module port_softreset_ctl
  import prt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned NUM_EVT   = 2,
  parameter int unsigned PWR_W     = 4,
  parameter int unsigned MIN_PULSE = 4,
  parameter logic [7:0]  PORT_ID   = 8'h03
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  input  logic               reqIssue,
  output logic               reqGrant,
  input  logic               reqDone,
  input  logic               mmioValid,
  output logic               mmioFwd,
  output logic               mmioErr,
  input  logic [NUM_EVT-1:0] evtSet,
  input  logic [PWR_W-1:0]   pwrState,
  output logic               accelRst
);
  prtStrobe_t strobe;
  logic reqBit, drainDone;

  prt_ctrl #(.MIN_PULSE(MIN_PULSE)) uCtrl (
    .clk(clk), .rstN(rstN), .reqBit(reqBit), .drainDone(drainDone),
    .strobe(strobe)
  );

  prt_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .PWR_W(PWR_W),
    .PORT_ID(PORT_ID)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqIssue(reqIssue), .reqGrant(reqGrant),
    .reqDone(reqDone), .mmioValid(mmioValid), .mmioFwd(mmioFwd),
    .mmioErr(mmioErr), .evtSet(evtSet), .pwrState(pwrState),
    .reqBit(reqBit), .drainDone(drainDone)
  );

  assign accelRst = strobe.portInRst;
endmodule

// File: tb/tb_port_softreset_ctl.sv
module tb_port_softreset_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic reqIssue = 1'b0, reqGrant, reqDone = 1'b0;
  logic mmioValid = 1'b0, mmioFwd, mmioErr;
  logic [1:0] evtSet = '0;
  logic [3:0] pwrState = 4'h5;
  logic accelRst;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_softreset_ctl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqIssue(reqIssue),
    .reqGrant(reqGrant), .reqDone(reqDone), .mmioValid(mmioValid),
    .mmioFwd(mmioFwd), .mmioErr(mmioErr), .evtSet(evtSet),
    .pwrState(pwrState), .accelRst(accelRst)
  );

  // {doWr, addr, wrData[11:0], evtSet, expected read[11:0]}
  typedef struct packed {
    logic doWr; logic [1:0] addr; logic [11:0] data; logic [1:0] evt; logic [11:0] exp;
  } vec_t;
  localparam vec_t VECS [9] = '{
    '{1'b1, 2'd0, 12'h101, 2'b00, 12'h111},  // R6 latency set
    '{1'b1, 2'd0, 12'h001, 2'b00, 12'h011},  // R6 latency clear, ack write ignored
    '{1'b0, 2'd1, 12'h000, 2'b11, 12'h503},  // R7 set both flags, R8 power
    '{1'b1, 2'd1, 12'h000, 2'b00, 12'h503},  // R7 write 0 keeps
    '{1'b1, 2'd1, 12'h001, 2'b00, 12'h502},  // R7 clear flag 0
    '{1'b1, 2'd1, 12'h002, 2'b00, 12'h500},  // R7 clear flag 1
    '{1'b1, 2'd2, 12'hFFF, 2'b00, 12'h003},  // R8 capability read-only
    '{1'b1, 2'd0, 12'h111, 2'b00, 12'h111},  // R6 ack bit read-only
    '{1'b0, 2'd3, 12'h000, 2'b00, 12'h000}   // R8 unused address
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [63:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [63:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    readReg(2'd0, rd);
    check("R1 ctrl", rd, 64'h011);
    check("R1 accelRst", {63'b0, accelRst}, 64'h1);

    // table of register vectors while held in reset
    for (int k = 0; k < 9; k++) begin
      evtSet = VECS[k].evt;
      if (VECS[k].doWr) writeReg(VECS[k].addr, {52'b0, VECS[k].data});
      else @(negedge clk);
      evtSet = '0;
      readReg(VECS[k].addr, rd);
      check("R6/R7/R8 vector", rd, {52'b0, VECS[k].exp});
    end

    // R5 access while held
    mmioValid = 1'b1; #1;
    check("R5 no fwd in reset", {63'b0, mmioFwd}, 64'h0);
    @(negedge clk); mmioValid = 1'b0;
    check("R5 err flagged", {63'b0, mmioErr}, 64'h1);

    // R3 exit from reset, latency kept at 1
    writeReg(2'd0, 64'h100);
    waitN(2);
    readReg(2'd0, rd);
    check("R3 ack held in settle", rd, 64'h110);
    check("R3 accelRst in settle", {63'b0, accelRst}, 64'h1);
    waitN(1);
    readReg(2'd0, rd);
    check("R3 ack cleared", rd, 64'h100);
    check("R3 accelRst released", {63'b0, accelRst}, 64'h0);

    // R4 R5 running behaviour, build two outstanding requests
    mmioValid = 1'b1; reqIssue = 1'b1; #1;
    check("R5 fwd when running", {63'b0, mmioFwd}, 64'h1);
    check("R4 grant when running", {63'b0, reqGrant}, 64'h1);
    waitN(2);
    mmioValid = 1'b0; reqIssue = 1'b0;
    check("R5 no err when running", {63'b0, mmioErr}, 64'h0);

    // R2 drain: request reset with two outstanding
    writeReg(2'd0, 64'h101);
    reqIssue = 1'b1; #1;
    check("R4 grant blocked", {63'b0, reqGrant}, 64'h0);
    reqIssue = 1'b0;
    waitN(10);
    readReg(2'd0, rd);
    check("R2 ack waits drain", rd, 64'h101);
    reqDone = 1'b1;
    waitN(2);
    reqDone = 1'b0;
    readReg(2'd0, rd);
    check("R2 ack after last done edge", rd, 64'h101);
    waitN(1);
    readReg(2'd0, rd);
    check("R2 ack after drain", rd, 64'h111);

    // exit again
    writeReg(2'd0, 64'h100);
    waitN(3);
    check("R3 running again", {63'b0, accelRst}, 64'h0);

    // R2 exact pulse width with nothing outstanding
    writeReg(2'd0, 64'h101);
    waitN(4);
    readReg(2'd0, rd);
    check("R2 ack not before width", rd, 64'h101);
    waitN(1);
    readReg(2'd0, rd);
    check("R2 ack at width", rd, 64'h111);
    writeReg(2'd0, 64'h100);
    waitN(3);

    // R9 clear during drain
    writeReg(2'd0, 64'h101);
    writeReg(2'd0, 64'h100);
    waitN(3);
    readReg(2'd0, rd);
    check("R9 no ack yet", rd, 64'h100);
    waitN(1);
    readReg(2'd0, rd);
    check("R9 ack raised", rd, 64'h110);
    waitN(2);
    check("R9 still in reset", {63'b0, accelRst}, 64'h1);
    waitN(1);
    check("R9 exit done", {63'b0, accelRst}, 64'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule